// File: doc/BRIEF.md
# Processor Bus Glue and Decoder

This block sits between a processor bus and an 8-bit peripheral register bank plus external ROM and RAM. It works out which target a bus cycle addresses, drives the chip selects and output enable, raises the read and write strobes for the register bank, and in one of its two modes produces the cycle-termination handshake, with wait states where a range needs them.

A strap sampled while reset is held picks the mode. In chip-select mode the processor's own programmable chip selects choose the register bank and the RAM, and the block terminates no cycles. In decode mode the processor is an asynchronous-bus CPU. The block decodes the top three address bits, acknowledges every range except the interrupt-acknowledge range, and answers that range with an autovector request. A boot phase after reset maps the ROM over the low two ranges until software writes the boot-clear register. The RAM select is held inactive for as long as the reset input is low.

Top module: `bus_glue`

## Requirements
- R1: `mode_strap` is sampled while reset is applied and held afterwards (0 = chip-select mode, 1 = decode mode). In chip-select mode, `dtack_n`, `vpa_n` and `rom_cs_n` stay high at all times.
- R2: In decode mode, while `as_n` is low, `dtack_n` is low with no wait states for top-bit codes 000, 001, 010, 011, 100 and 101. It stays high for code 111.
- R3: In decode mode, `vpa_n` is low only while `as_n` is low and the top-bit code is 111.
- R4: In both modes, `spare_cs_n` is low while `as_n` is low and the code is 110. In decode mode, `dtack_n` for code 110 goes low only once `as_n` has been sampled low on 2^`wait_sel` rising clock edges (`wait_sel` 0..3 gives 1, 2, 4 or 8 wait states).
- R5: `ram_cs_n` is high whenever `rst_n` is low. In chip-select mode, while reset is released, it equals `ram_sel_in_n`, whatever the state of `as_n`.
- R6: In decode mode, while boot is in force, `rom_cs_n` is low with `as_n` low for codes 000 and 001, and `ram_cs_n` stays high. Once boot has ended, `rom_cs_n` is low only for code 000 and `ram_cs_n` is low only for code 001, in each case with `as_n` low.
- R7: Boot starts at reset. It ends at the first rising clock edge that samples a register write to offset 0xFF. A register write to any other offset leaves boot in force.
- R8: `oe_n` is low exactly when `as_n` is low and `rw` is high (1 = read).
- R9: The register bank is selected by `periph_cs_in_n` low in chip-select mode and by code 010 in decode mode. With `as_n` low, `reg_rd` follows a read and `reg_wr` follows a write to the selected bank. `reg_addr` always equals `addr_lo`.
- R10: `dtack_n`, `vpa_n` and every chip select go high as soon as `as_n` rises. The next cycle counts its wait states afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; wait states are counted in its periods |
| rst_n | input | 1 | Asynchronous active-low reset; also gates the RAM select |
| mode_strap | input | 1 | Mode strap, sampled during reset: 0 chip-select, 1 decode |
| as_n | input | 1 | Address strobe, active low; also the register data strobe |
| rw | input | 1 | Read (1) or write (0) |
| addr_hi | input | 3 | Top three address bits, the range code |
| addr_lo | input | 8 | Register offset within the peripheral range |
| periph_cs_in_n | input | 1 | Register-bank select from the processor (chip-select mode) |
| ram_sel_in_n | input | 1 | RAM select from the processor (chip-select mode) |
| wait_sel | input | 2 | Wait-state choice for the spare range |
| dtack_n | output | 1 | Cycle acknowledge, active low (decode mode) |
| vpa_n | output | 1 | Autovector request for interrupt acknowledge, active low |
| rom_cs_n | output | 1 | ROM select, active low (decode mode) |
| ram_cs_n | output | 1 | Write-protected RAM select, active low |
| spare_cs_n | output | 1 | Spare-range chip select, active low |
| oe_n | output | 1 | Output enable for RAM and ROM, active low |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 8 | Register offset passed to the bank |

## Verification
The assertions assume that `as_n` stays high for at least one rising clock edge between bus cycles, so that the wait counter is cleared before the next strobe falls. They also assume that the address, `rw` and `wait_sel` are steady while `as_n` is low. The stimulus changes inputs only at falling clock edges and starts every cycle from a strobe that has been high across a rising edge. It also holds the strap constant through each reset, which the mode capture relies on.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam int HI_W   = 3;
  localparam int OFS_W  = 8;
  localparam int SEL_W  = 2;
  localparam logic [HI_W-1:0] CODE_ROM   = 3'b000;
  localparam logic [HI_W-1:0] CODE_RAM   = 3'b001;
  localparam logic [HI_W-1:0] CODE_REGS  = 3'b010;
  localparam logic [HI_W-1:0] CODE_SPARE = 3'b110;
  localparam logic [HI_W-1:0] CODE_IACK  = 3'b111;
  localparam logic [OFS_W-1:0] BOOT_CLR_OFS = 8'hFF;
endpackage

// File: rtl/glue_rst_sync.sv
module glue_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/glue_wait.sv
module glue_wait
  import glue_pkg::*;
#(
  parameter int WSEL_W = SEL_W
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              as_n,
  input  logic [WSEL_W-1:0] wait_sel,
  input  logic              boot_clr,
  output logic              wait_done,
  output logic              boot
);
  localparam int NSEL     = 1 << WSEL_W;
  localparam int MAX_WAIT = 1 << (NSEL - 1);
  localparam int CW       = $clog2(MAX_WAIT + 1);

  logic [CW-1:0] thr [NSEL];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          boot_q, boot_d;

  for (genvar i = 0; i < NSEL; i++) begin : g_thr
    assign thr[i] = CW'(1 << i);
  end

  always_comb begin
    if (as_n)                          cnt_d = '0;
    else if (cnt_q == CW'(MAX_WAIT))   cnt_d = cnt_q;
    else                               cnt_d = cnt_q + 1'b1;
    boot_d = boot_q & ~boot_clr;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cnt_q  <= '0;
      boot_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      boot_q <= boot_d;
    end
  end

  assign wait_done = (cnt_q >= thr[wait_sel]);
  assign boot      = boot_q;
endmodule

// File: rtl/glue_decode.sv
module glue_decode
  import glue_pkg::*;
(
  input  logic            mode_b,
  input  logic            boot,
  input  logic            rst_n,
  input  logic            as_n,
  input  logic            rw,
  input  logic [HI_W-1:0] addr_hi,
  input  logic            periph_cs_in_n,
  input  logic            ram_sel_in_n,
  input  logic            wait_done,
  output logic            dtack_n,
  output logic            vpa_n,
  output logic            rom_cs_n,
  output logic            ram_cs_n,
  output logic            spare_cs_n,
  output logic            oe_n,
  output logic            reg_rd,
  output logic            reg_wr
);
  logic strb, regs_sel, hit_rom, hit_ram;

  always_comb begin
    strb     = ~as_n;
    regs_sel = mode_b ? (addr_hi == CODE_REGS) : ~periph_cs_in_n;
    hit_rom  = (addr_hi == CODE_ROM) | (boot & (addr_hi == CODE_RAM));
    hit_ram  = (addr_hi == CODE_RAM) & ~boot;

    dtack_n = 1'b1;
    vpa_n   = 1'b1;
    if (mode_b && strb) begin
      if (addr_hi == CODE_IACK)       vpa_n   = 1'b0;
      else if (addr_hi == CODE_SPARE) dtack_n = ~wait_done;
      else                            dtack_n = 1'b0;
    end

    rom_cs_n   = ~(mode_b & strb & hit_rom);
    if (mode_b) ram_cs_n = ~(rst_n & strb & hit_ram);
    else        ram_cs_n = ram_sel_in_n | ~rst_n;
    spare_cs_n = ~(strb & (addr_hi == CODE_SPARE));
    oe_n       = ~(strb & rw);
    reg_rd     = strb & regs_sel & rw;
    reg_wr     = strb & regs_sel & ~rw;
  end
endmodule

// File: rtl/bus_glue.sv
module bus_glue
  import glue_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_strap,
  input  logic             as_n,
  input  logic             rw,
  input  logic [HI_W-1:0]  addr_hi,
  input  logic [OFS_W-1:0] addr_lo,
  input  logic             periph_cs_in_n,
  input  logic             ram_sel_in_n,
  input  logic [SEL_W-1:0] wait_sel,
  output logic             dtack_n,
  output logic             vpa_n,
  output logic             rom_cs_n,
  output logic             ram_cs_n,
  output logic             spare_cs_n,
  output logic             oe_n,
  output logic             reg_rd,
  output logic             reg_wr,
  output logic [OFS_W-1:0] reg_addr
);
  logic rst_q_n, mode_q, mode_d, wait_done, boot, boot_clr;

  glue_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  // strap is captured every edge while the synchronized reset is active
  always_comb mode_d = rst_q_n ? mode_q : mode_strap;

  always_ff @(posedge clk) begin
    mode_q <= mode_d;
  end

  assign boot_clr = reg_wr & (addr_lo == BOOT_CLR_OFS);

  glue_wait #(.WSEL_W(SEL_W)) u_wait (
    .clk(clk), .rst_q_n(rst_q_n), .as_n(as_n), .wait_sel(wait_sel),
    .boot_clr(boot_clr), .wait_done(wait_done), .boot(boot)
  );

  glue_decode u_dec (
    .mode_b(mode_q), .boot(boot), .rst_n(rst_n), .as_n(as_n), .rw(rw),
    .addr_hi(addr_hi), .periph_cs_in_n(periph_cs_in_n),
    .ram_sel_in_n(ram_sel_in_n), .wait_done(wait_done),
    .dtack_n(dtack_n), .vpa_n(vpa_n), .rom_cs_n(rom_cs_n),
    .ram_cs_n(ram_cs_n), .spare_cs_n(spare_cs_n), .oe_n(oe_n),
    .reg_rd(reg_rd), .reg_wr(reg_wr)
  );

  assign reg_addr = addr_lo;
endmodule

// File: rtl/bus_glue_chk.sv
module bus_glue_chk
  import glue_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            as_n,
  input logic [HI_W-1:0] addr_hi,
  input logic            dtack_n,
  input logic            vpa_n,
  input logic            rom_cs_n,
  input logic            ram_cs_n,
  input logic            spare_cs_n,
  input logic            oe_n,
  input logic            reg_rd,
  input logic            reg_wr
);
  assert_vpa_only_iack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vpa_n |-> (!as_n && addr_hi == CODE_IACK));

  assert_spare_first_edge_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && $past(as_n) && addr_hi == CODE_SPARE) |-> dtack_n);

  assert_release_on_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (dtack_n && vpa_n && rom_cs_n && spare_cs_n && oe_n && !reg_rd && !reg_wr));

  assert_no_double_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !vpa_n));

  assert_rom_ram_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_cs_n && !ram_cs_n));

  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_rd, reg_wr}));

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_ram_protect_R5: assert (ram_cs_n);
    end
  end
endmodule

bind bus_glue bus_glue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .addr_hi(addr_hi),
  .dtack_n(dtack_n), .vpa_n(vpa_n), .rom_cs_n(rom_cs_n),
  .ram_cs_n(ram_cs_n), .spare_cs_n(spare_cs_n), .oe_n(oe_n),
  .reg_rd(reg_rd), .reg_wr(reg_wr)
);

// File: tb/bus_glue_bench.sv
module bus_glue_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n, mode_strap, as_n, rw, periph_cs_in_n, ram_sel_in_n;
  logic [2:0] addr_hi;
  logic [7:0] addr_lo;
  logic [1:0] wait_sel;
  logic       dtack_n, vpa_n, rom_cs_n, ram_cs_n, spare_cs_n, oe_n, reg_rd, reg_wr;
  logic [7:0] reg_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit m_modeb, m_boot;

  always #(CLK_P/2) clk = ~clk;

  bus_glue u_bus_glue (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .as_n(as_n), .rw(rw),
    .addr_hi(addr_hi), .addr_lo(addr_lo), .periph_cs_in_n(periph_cs_in_n),
    .ram_sel_in_n(ram_sel_in_n), .wait_sel(wait_sel), .dtack_n(dtack_n),
    .vpa_n(vpa_n), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
    .spare_cs_n(spare_cs_n), .oe_n(oe_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // expected outputs from the requirements, k = rising edges seen with strobe low
  task automatic check_all(input bit strobe, input int k);
    bit s, sel;
    int n;
    s   = strobe;
    n   = 1 << wait_sel;
    sel = m_modeb ? (addr_hi == 3'b010) : !periph_cs_in_n;
    if (m_modeb) begin
      chk("R2 R4 dtack_n", dtack_n,
          !s ? 1'b1 : (addr_hi == 3'b111) ? 1'b1 : (addr_hi == 3'b110) ? (k < n) : 1'b0);
      chk("R3 vpa_n", vpa_n, !(s && addr_hi == 3'b111));
      chk("R6 rom_cs_n", rom_cs_n,
          !(s && (addr_hi == 3'b000 || (m_boot && addr_hi == 3'b001))));
      chk("R6 ram_cs_n", ram_cs_n, !(s && !m_boot && addr_hi == 3'b001));
    end else begin
      chk("R1 dtack_n", dtack_n, 1'b1);
      chk("R1 vpa_n", vpa_n, 1'b1);
      chk("R1 rom_cs_n", rom_cs_n, 1'b1);
      chk("R5 ram_cs_n", ram_cs_n, ram_sel_in_n);
    end
    chk("R4 spare_cs_n", spare_cs_n, !(s && addr_hi == 3'b110));
    chk("R8 oe_n", oe_n, !(s && rw));
    chk("R9 reg_rd", reg_rd, s && sel && rw);
    chk("R9 reg_wr", reg_wr, s && sel && !rw);
    n_chk++;
    if (reg_addr !== addr_lo) begin
      n_fail++;
      $display("FAIL R9 reg_addr act=%0h exp=%0h", reg_addr, addr_lo);
    end
  endtask

  task automatic bus_cycle(input logic [2:0] code, input logic [7:0] lo, input logic r,
                           input logic pcs, input logic rin);
    int hold;
    @(negedge clk);
    addr_hi = code; addr_lo = lo; rw = r; periph_cs_in_n = pcs; ram_sel_in_n = rin;
    as_n = 1'b0;
    #1 check_all(1'b1, 0);
    hold = (m_modeb && code == 3'b110) ? (1 << wait_sel) + 1 : 1;
    for (int k = 1; k <= hold; k++) begin
      @(negedge clk);
      #1 check_all(1'b1, k);
    end
    as_n = 1'b1;
    #1 check_all(1'b0, 0); // R10 release at once
    if (!r && lo == 8'hFF && (m_modeb ? code == 3'b010 : !pcs)) m_boot = 1'b0; // R7
    @(posedge clk);
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; mode_strap = strap;
    repeat (4) @(negedge clk);
    #1 check_all(1'b0, 0);
    chk("R5 ram_cs_n in reset", ram_cs_n, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mode_strap = ~strap; // R1 strap ignored after reset
    m_modeb = strap; m_boot = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; mode_strap = 1'b1; as_n = 1'b1; rw = 1'b1; addr_hi = '0; addr_lo = '0;
    periph_cs_in_n = 1'b1; ram_sel_in_n = 1'b1; wait_sel = 2'd0;
    m_modeb = 1'b1; m_boot = 1'b1;

    // decode mode, boot in force
    do_reset(1'b1);
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 2; r++)
        bus_cycle(3'(c), 8'h3C, 1'(r), 1'b1, 1'b1);
    bus_cycle(3'b010, 8'hFE, 1'b0, 1'b1, 1'b1); // R7 other offset: boot stays
    bus_cycle(3'b001, 8'h00, 1'b1, 1'b1, 1'b1);
    for (int w = 0; w < 4; w++) begin           // R4 every wait choice
      wait_sel = 2'(w);
      bus_cycle(3'b110, 8'h10, 1'b1, 1'b1, 1'b1);
      bus_cycle(3'b110, 8'h11, 1'b0, 1'b1, 1'b1); // R10 counted afresh
    end
    bus_cycle(3'b010, 8'hFF, 1'b0, 1'b1, 1'b1); // R7 boot clear
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 2; r++)
        bus_cycle(3'(c), 8'hA5, 1'(r), 1'b1, 1'b1);

    // chip-select mode
    do_reset(1'b0);
    for (int c = 0; c < 8; c++)
      for (int v = 0; v < 8; v++)
        bus_cycle(3'(c), 8'(c * 8 + v), 1'(v & 1), 1'((v >> 1) & 1), 1'((v >> 2) & 1));
    @(negedge clk);
    ram_sel_in_n = 1'b0; as_n = 1'b1;
    #1 chk("R5 ram_cs_n follows input idle", ram_cs_n, 1'b0);
    rst_n = 1'b0;
    #1 chk("R5 ram_cs_n forced high in reset", ram_cs_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    ram_sel_in_n = 1'b1;

    // back to decode mode: boot restored by reset
    do_reset(1'b1);
    bus_cycle(3'b001, 8'h00, 1'b1, 1'b1, 1'b1);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule